// File: doc/BRIEF.md
# Integer Execution Unit with Selective Overflow

A purely combinational 32-bit integer unit for the execute stage of a load-store RISC pipeline. Every cycle it takes two register operands, a 16-bit immediate field, a 5-bit constant shift field and an operation code. From these it returns a full-width result together with a signed-overflow flag. It covers addition and subtraction, with and without overflow reporting. It also covers the four bitwise functions, signed and unsigned less-than tests, constant and register-controlled shifts, and the upper-immediate construction.

The second operand is the register value or the extended immediate. The immediate is zero-filled for the bitwise-immediate operations and sign-filled for every arithmetic or compare-immediate operation. The unit only raises the overflow flag. The wrapped result is still driven, and the surrounding core decides whether to trap and drop the write-back.

Top module: `int_exec_alu`

## Requirements
- R1: Codes ADD=0, ADDU=1, ADDI=10 and ADDIU=11 return the 32-bit wrapped sum of src_a and the second operand. The second operand is src_b for register forms and the sign-extended imm16 for immediate forms.
- R2: ovf may be 1 only for codes ADD=0, SUB=2 and ADDI=10. It is 0 for every other code, including ADDU, SUBU, ADDIU, the bitwise operations and the shifts, even with operands that overflow.
- R3: For ADD and ADDI, ovf is 1 when both addends share a sign and the sum's sign differs. For SUB, ovf is 1 when the operands' signs differ and the difference's sign differs from src_a's. The wrapped result is still driven when ovf is 1.
- R4: Codes SUB=2 and SUBU=3 return src_a minus src_b modulo 2^32.
- R5: Codes AND=4, OR=5, XOR=6 and NOR=7 apply the bitwise function to src_a and src_b. NOR is the complement of the OR.
- R6: Codes ANDI=14, ORI=15 and XORI=16 apply AND, OR or XOR to src_a and imm16 zero-extended to 32 bits.
- R7: Codes SLT=8 and SLTI=12 compare src_a with the second operand as two's-complement numbers. Codes SLTU=9 and SLTIU=13 compare them as unsigned numbers, with the SLTIU immediate still sign-extended. The result is 1 when src_a is less, else 0, in bit 0 with bits 31:1 clear.
- R8: Code LUI=17 returns imm16 in bits 31:16 and zeros in bits 15:0, whatever src_a and src_b hold.
- R9: Codes SLL=18, SRL=19 and SRA=20 shift src_b left logically, right logically or right arithmetically by shamt. The arithmetic form replicates bit 31.
- R10: Codes SLLV=21, SRLV=22 and SRAV=23 perform the same three shifts of src_b by src_a[4:0]. Bits 31:5 of src_a have no effect.
- R11: Any code from 24 to 31 returns result 0 and ovf 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (values in R1 to R11) |
| src_a | input | 32 | First register operand; register shift amount in bits 4:0 |
| src_b | input | 32 | Second register operand; value shifted by shift operations |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of ADD, SUB or ADDI |

## Verification
Two outputs can carry news in the same cycle: the overflow flag rises while the result still shows the wrapped sum or difference. The bench provokes this at the signed extremes, for example 0x7FFFFFFF plus 1 and 0x80000000 minus 1, in the trapping form and the non-trapping form. It then judges both ports against a reference model that uses 64-bit signed arithmetic. The same operand pairs are replayed under the bitwise, shift and undefined codes to confirm that the flag stays low there.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int ALU_W = 32;
  localparam int IMM_W = 16;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
    OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR   = 5'd6,  OP_NOR   = 5'd7,
    OP_SLT   = 5'd8,  OP_SLTU  = 5'd9,  OP_ADDI  = 5'd10, OP_ADDIU = 5'd11,
    OP_SLTI  = 5'd12, OP_SLTIU = 5'd13, OP_ANDI  = 5'd14, OP_ORI   = 5'd15,
    OP_XORI  = 5'd16, OP_LUI   = 5'd17, OP_SLL   = 5'd18, OP_SRL   = 5'd19,
    OP_SRA   = 5'd20, OP_SLLV  = 5'd21, OP_SRLV  = 5'd22, OP_SRAV  = 5'd23
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;

  // signed overflow of a sum, from the sign bits of the addends and the sum
  function automatic logic add_sign_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // signed overflow of a difference a-b
  function automatic logic sub_sign_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

  function automatic logic is_trapping(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
  endfunction

  function automatic logic is_subtract(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) ||
           (op == OP_SLTU) || (op == OP_SLTI) || (op == OP_SLTIU);
  endfunction

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
  import int_alu_pkg::*;
#(
  parameter int W   = ALU_W,
  parameter int IW  = IMM_W
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   reg_b,
  input  logic [IW-1:0]  imm,
  output logic [W-1:0]   opnd_b
);
  localparam int PAD = W - IW;

  logic [W-1:0] imm_sx;
  logic [W-1:0] imm_zx;

  assign imm_sx = {{PAD{imm[IW-1]}}, imm};
  assign imm_zx = {{PAD{1'b0}}, imm};

  always_comb begin
    case (op)
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: opnd_b = imm_sx;
      OP_ANDI, OP_ORI, OP_XORI:             opnd_b = imm_zx;
      default:                              opnd_b = reg_b;
    endcase
  end

  always_comb begin
    if (op == OP_ANDI || op == OP_ORI || op == OP_XORI) begin
      p_logic_imm_zero_fill_r6: assert (opnd_b[W-1:IW] == '0 && opnd_b[IW-1:0] == imm)
        else $error("logical immediate not zero-filled");
    end
    if (op == OP_ADDI || op == OP_SLTIU) begin
      p_arith_imm_sign_fill_r1: assert ($signed(opnd_b) == $signed(imm))
        else $error("arithmetic immediate not sign-filled");
    end
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import int_alu_pkg::*;
#(
  parameter int W = ALU_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] res,
  output logic         ovf_raw,
  output logic         lt_signed,
  output logic         lt_unsigned
);
  logic [W-1:0] b_inv;
  logic         carry_out;

  assign b_inv = do_sub ? ~b : b;
  assign {carry_out, res} = {1'b0, a} + {1'b0, b_inv} + {{W{1'b0}}, do_sub};

  assign ovf_raw     = do_sub ? sub_sign_ovf(a[W-1], b[W-1], res[W-1])
                              : add_sign_ovf(a[W-1], b[W-1], res[W-1]);
  assign lt_signed   = res[W-1] ^ ovf_raw;
  assign lt_unsigned = ~carry_out;

  // wide reference built from sign-extended operands
  logic [W:0] wide;
  assign wide = do_sub ? ({a[W-1], a} - {b[W-1], b}) : ({a[W-1], a} + {b[W-1], b});

  always_comb begin
    p_ovf_matches_wide_r3: assert (ovf_raw == (wide[W] != wide[W-1]))
      else $error("overflow disagrees with widened arithmetic");
    if (do_sub) begin
      p_unsigned_lt_r7: assert (lt_unsigned == (a < b))
        else $error("unsigned less-than wrong");
      p_signed_lt_r7: assert (lt_signed == ($signed(a) < $signed(b)))
        else $error("signed less-than wrong");
    end
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import int_alu_pkg::*;
#(
  parameter int W = ALU_W
) (
  input  logic [W-1:0]          val,
  input  logic [$clog2(W)-1:0]  amt,
  input  shift_kind_e           kind,
  output logic [W-1:0]          res
);
  localparam int SH_W = $clog2(W);

  logic [W-1:0] pre;
  logic [W-1:0] post;
  logic [W-1:0] stage [SH_W+1];
  logic         fill;
  logic         left;

  assign left = (kind == SH_LEFT);
  assign fill = (kind == SH_RARI) & val[W-1];

  // left shifts run through the right-shift network with bits reversed
  for (genvar k = 0; k < W; k++) begin : g_rev
    assign pre[k]  = left ? val[W-1-k] : val[k];
    assign res[k]  = left ? post[W-1-k] : post[k];
  end

  assign stage[0] = pre;
  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stage[i+1] = amt[i] ? {{STEP{fill}}, stage[i][W-1:STEP]} : stage[i];
  end
  assign post = stage[SH_W];

  always_comb begin
    case (kind)
      SH_LEFT: p_shift_left_r9: assert (res == (val << amt))
                 else $error("left shift mismatch");
      SH_RLOG: p_shift_rlog_r9: assert (res == (val >> amt))
                 else $error("logical right shift mismatch");
      SH_RARI: p_shift_rari_r9: assert (res == W'($signed(val) >>> amt))
                 else $error("arithmetic right shift mismatch");
      default: ;
    endcase
  end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_alu_pkg::*;
#(
  parameter int W  = ALU_W,
  parameter int IW = IMM_W
) (
  input  logic [4:0]            op_sel,
  input  logic [W-1:0]          src_a,
  input  logic [W-1:0]          src_b,
  input  logic [IW-1:0]         imm16,
  input  logic [$clog2(W)-1:0]  shamt,
  output logic [W-1:0]          result,
  output logic                  ovf
);
  localparam int SH_W = $clog2(W);

  alu_op_e      op;
  logic [W-1:0] opnd_b;
  logic [W-1:0] as_res;
  logic         as_ovf;
  logic         lt_s;
  logic         lt_u;
  logic [W-1:0] sh_res;
  logic [SH_W-1:0] sh_amt;
  shift_kind_e  sh_kind;
  logic         do_sub;

  assign op     = alu_op_e'(op_sel);
  assign do_sub = is_subtract(op);

  alu_opnd_sel #(.W(W), .IW(IW)) u_opnd (
    .op     (op),
    .reg_b  (src_b),
    .imm    (imm16),
    .opnd_b (opnd_b)
  );

  alu_addsub #(.W(W)) u_addsub (
    .a           (src_a),
    .b           (opnd_b),
    .do_sub      (do_sub),
    .res         (as_res),
    .ovf_raw     (as_ovf),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  always_comb begin
    case (op)
      OP_SRL, OP_SRLV: sh_kind = SH_RLOG;
      OP_SRA, OP_SRAV: sh_kind = SH_RARI;
      default:         sh_kind = SH_LEFT;
    endcase
    case (op)
      OP_SLLV, OP_SRLV, OP_SRAV: sh_amt = src_a[SH_W-1:0];
      default:                   sh_amt = shamt;
    endcase
  end

  alu_shift #(.W(W)) u_shift (
    .val  (src_b),
    .amt  (sh_amt),
    .kind (sh_kind),
    .res  (sh_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
      OP_ADDI, OP_ADDIU:                 result = as_res;
      OP_AND, OP_ANDI:                   result = src_a & opnd_b;
      OP_OR,  OP_ORI:                    result = src_a | opnd_b;
      OP_XOR, OP_XORI:                   result = src_a ^ opnd_b;
      OP_NOR:                            result = ~(src_a | opnd_b);
      OP_SLT, OP_SLTI:                   result = {{(W-1){1'b0}}, lt_s};
      OP_SLTU, OP_SLTIU:                 result = {{(W-1){1'b0}}, lt_u};
      OP_LUI:                            result = {imm16, {(W-IW){1'b0}}};
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:         result = sh_res;
      default:                           result = '0;
    endcase
  end

  assign ovf = as_ovf & is_trapping(op);

  always_comb begin
    if (ovf) begin
      p_no_overflow_r2: assert (op_sel == 5'd0 || op_sel == 5'd2 || op_sel == 5'd10)
        else $error("overflow raised for a non-trapping code");
      p_ovf_keeps_result_r3: assert (result == (op_sel == 5'd2 ? src_a - src_b : src_a + opnd_b))
        else $error("wrapped result not driven under overflow");
    end
    if (op_sel == 5'd17) begin
      p_lui_layout_r8: assert (result[IW-1:0] == '0 && result[W-1:W-IW] == imm16)
        else $error("upper immediate layout wrong");
    end
    if (op_sel == 5'd8 || op_sel == 5'd9 || op_sel == 5'd12 || op_sel == 5'd13) begin
      p_compare_bool_r7: assert (result[W-1:1] == '0)
        else $error("compare result not boolean");
    end
    if (op_sel > 5'd23) begin
      p_undefined_quiet_r11: assert (result == '0 && !ovf)
        else $error("undefined code not quiet");
    end
  end

endmodule

// File: tb/int_exec_alu_tb.sv
module int_exec_alu_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  op_sel = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf;

  int_exec_alu u_dut (
    .op_sel (op_sel),
    .src_a  (src_a),
    .src_b  (src_b),
    .imm16  (imm16),
    .shamt  (shamt),
    .result (result),
    .ovf    (ovf)
  );

  typedef struct {
    logic [31:0] exp_res;
    logic        exp_ovf;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // reference model: 64-bit signed arithmetic
  function automatic void model(input int op, input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] im, input logic [4:0] sh,
                                output logic [31:0] r, output logic v);
    longint sa, sb2, s;
    logic [31:0] isx, izx;
    isx = {{16{im[15]}}, im};
    izx = {16'h0000, im};
    sa  = longint'($signed(a));
    r = '0; v = 1'b0;
    case (op)
      0, 1, 10, 11: begin
        sb2 = (op >= 10) ? longint'($signed(isx)) : longint'($signed(b));
        s = sa + sb2;
        r = s[31:0];
        v = (op != 1 && op != 11) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      2, 3: begin
        s = sa - longint'($signed(b));
        r = s[31:0];
        v = (op == 2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      4:  r = a & b;
      5:  r = a | b;
      6:  r = a ^ b;
      7:  r = ~(a | b);
      8:  r = {31'b0, $signed(a) < $signed(b)};
      9:  r = {31'b0, a < b};
      12: r = {31'b0, $signed(a) < $signed(isx)};
      13: r = {31'b0, a < isx};
      14: r = a & izx;
      15: r = a | izx;
      16: r = a ^ izx;
      17: r = {im, 16'h0000};
      18: r = b << sh;
      19: r = b >> sh;
      20: r = 32'($signed(b) >>> sh);
      21: r = b << a[4:0];
      22: r = b >> a[4:0];
      23: r = 32'($signed(b) >>> a[4:0]);
      default: begin r = '0; v = 1'b0; end
    endcase
  endfunction

  task automatic drive(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input string req);
    sb_item_t it;
    @(posedge clk);
    op_sel = 5'(op); src_a = a; src_b = b; imm16 = im; shamt = sh;
    model(op, a, b, im, sh, it.exp_res, it.exp_ovf);
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: sample away from the driving edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (result !== it.exp_res || ovf !== it.exp_ovf) begin
        failures++;
        $display("FAIL %s: op=%0d result=%h ovf=%b expected result=%h ovf=%b",
                 it.req, op_sel, result, ovf, it.exp_res, it.exp_ovf);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: idle state with all-zero inputs
    drive(0, 32'h0, 32'h0, 16'h0, 5'd0, "R1 reset-state");
    drive(0, 32'd5, 32'd7, 16'h0, 5'd0, "R1 add");
    drive(11, 32'd100, 32'h0, 16'hFFFF, 5'd0, "R1 addiu sign-extended");
    drive(10, 32'd100, 32'h0, 16'hFFFF, 5'd0, "R1 addi negative imm");
    // R3: overflow with wrapped result
    drive(0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, "R3 add positive overflow");
    drive(0, 32'h80000000, 32'h80000000, 16'h0, 5'd0, "R3 add negative overflow");
    drive(2, 32'h80000000, 32'h1, 16'h0, 5'd0, "R3 sub overflow");
    drive(2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0, "R3 sub overflow up");
    drive(10, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, "R3 addi overflow");
    drive(0, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0, "R3 mixed signs no overflow");
    // R2: non-trapping forms stay quiet
    drive(1, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, "R2 addu quiet");
    drive(3, 32'h80000000, 32'h1, 16'h0, 5'd0, "R2 subu quiet");
    drive(11, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, "R2 addiu quiet");
    drive(5, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, "R2 or quiet");
    drive(18, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'h0, 5'd1, "R2 shift quiet");
    // R4
    drive(2, 32'd3, 32'd5, 16'h0, 5'd0, "R4 sub negative");
    drive(3, 32'd0, 32'd1, 16'h0, 5'd0, "R4 subu wrap");
    // R5
    drive(4, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 5'd0, "R5 and");
    drive(5, 32'hF0F0_1234, 32'h0F00_00FF, 16'h0, 5'd0, "R5 or");
    drive(6, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 5'd0, "R5 xor");
    drive(7, 32'hF0F0_0000, 32'h0000_000F, 16'h0, 5'd0, "R5 nor");
    // R6
    drive(14, 32'hFFFFFFFF, 32'h0, 16'h8000, 5'd0, "R6 andi zero-fill");
    drive(15, 32'h0, 32'h0, 16'hF00F, 5'd0, "R6 ori zero-fill");
    drive(16, 32'hFFFF0000, 32'h0, 16'hFFFF, 5'd0, "R6 xori zero-fill");
    // R7
    drive(8, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, "R7 slt signed");
    drive(9, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, "R7 sltu unsigned");
    drive(8, 32'h5, 32'h5, 16'h0, 5'd0, "R7 slt equal");
    drive(8, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0, "R7 slt extremes");
    drive(12, 32'h0, 32'h0, 16'hFFFF, 5'd0, "R7 slti negative imm");
    drive(13, 32'h5, 32'h0, 16'hFFFF, 5'd0, "R7 sltiu sign-extended imm");
    // R8
    drive(17, 32'hDEADBEEF, 32'h12345678, 16'hABCD, 5'd3, "R8 lui");
    // R9
    drive(18, 32'h0, 32'h1, 16'h0, 5'd31, "R9 sll by 31");
    drive(19, 32'h0, 32'h80000000, 16'h0, 5'd31, "R9 srl by 31");
    drive(20, 32'h0, 32'h80000000, 16'h0, 5'd4, "R9 sra sign fill");
    drive(20, 32'h0, 32'h9000_0001, 16'h0, 5'd0, "R9 sra by zero");
    // R10
    drive(21, 32'hFFFFFFE3, 32'h1, 16'h0, 5'd30, "R10 sllv low bits only");
    drive(22, 32'h0000_0024, 32'hF000_0000, 16'h0, 5'd0, "R10 srlv low bits only");
    drive(23, 32'h8000_0008, 32'h8000_0000, 16'h0, 5'd1, "R10 srav");
    // R11
    drive(24, 32'h7FFFFFFF, 32'h1, 16'hFFFF, 5'd3, "R11 undefined 24");
    drive(31, 32'h80000000, 32'h80000000, 16'h1234, 5'd7, "R11 undefined 31");
    // mixed sweep over every code
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 256; n++) begin
      logic [31:0] x, y;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      y = lfsr ^ {x[15:0], x[31:16]};
      drive(n % 32, x, y, y[23:8], x[9:5], "R1 R2 R3 R11 sweep");
    end
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule